// File: doc/BRIEF.md
# Table-Jump Instruction Expander

This block sits in the decode path of a small 32-bit RISC-V core that has no address translation. The compressed decoder flags the two table-jump instructions, cm.jt and cm.jalt. For either one, the block takes the 8-bit table index from the instruction. It adds the index to the jump-table base supplied by a CSR and reads the table entry through a simple request/grant/data-valid port into the data cache. While that read is in flight it holds fetch. When the entry arrives, it emits a JAL whose offset reaches the fetched target from the current PC.

Every other instruction passes through unchanged, together with its illegal and compressed flags. The output stage is registered, so the result of a consumed input appears one cycle later. The fetch-stall output is combinational: upstream advances on any edge where it is low. The instruction it presented at that edge is then consumed.

Top module: `tblj_expander`

## Requirements
- R1: While `rst` (synchronous, active high) is asserted and in the first cycle after it: `mem_req` is 0, `fetch_stall` is 0, `out_instr` is 0x00000013 and both output flags are 0.
- R2: A consumed input with `in_is_tj` = 0 appears on `out_instr`, `out_illegal` and `out_compressed` unchanged, one clock after the edge that consumed it.
- R3: The table read address equals the CSR base with bits [5:0] cleared, plus four times the index. The index is `in_instr[9:2]`.
- R4: `mem_req` rises in the cycle after a table jump is detected. It stays high, with `mem_addr` unchanged, until the edge at which `mem_gnt` is seen, and falls after that edge.
- R5: `fetch_stall` is high from the cycle a table jump is presented until the cycle in which its entry arrives: `mem_rvalid` in the wait phase, or `mem_gnt` together with `mem_rvalid` in the request phase. In that arrival cycle it is low.
- R6: An index below 32 (cm.jt) yields rd = x0 in bits [11:7] of the emitted instruction. An index of 32 or more (cm.jalt) yields rd = x1.
- R7: The emitted instruction is a JAL (opcode 0x6F in bits [6:0]). Its 21-bit J-type immediate is the fetched target minus the PC of the table jump, with imm[20] in bit 31, imm[10:1] in bits [30:21], imm[11] in bit 20 and imm[19:12] in bits [19:12]. It is emitted with `out_compressed` = 1 and `out_illegal` = 0, one clock after the entry arrives.
- R8: When grant and data-valid arrive in the same cycle, the read completes in that cycle, with no wait phase.
- R9: From the cycle after detection until the JAL is emitted, `out_instr` shows 0x00000013 with both flags 0.
- R10: `mem_rvalid` before the grant is ignored. Changes on the instruction, PC and CSR inputs during a read do not alter the address or the emitted JAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_instr | input | 32 | Instruction from the compressed decoder |
| in_pc | input | 32 | PC of that instruction |
| in_is_tj | input | 1 | Marks a table-jump instruction |
| in_illegal | input | 1 | Illegal flag from the compressed decoder |
| in_compressed | input | 1 | Compressed flag from the compressed decoder |
| tbl_base | input | 32 | Jump-table base from the CSR |
| mem_req | output | 1 | Read request to the data cache |
| mem_addr | output | 32 | Read address |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (table entry) |
| out_instr | output | 32 | Instruction to the next stage |
| out_illegal | output | 1 | Illegal flag to the next stage |
| out_compressed | output | 1 | Compressed flag to the next stage |
| fetch_stall | output | 1 | Hold fetch; presented instruction not consumed |

## Verification
The grant and the data return can fall in the same cycle. In that case the request phase must both finish the read and drop the stall, skipping the wait phase. The memory responder in the bench is set to zero-latency data, so that it returns data on the grant edge, both with and without delayed grants. The reference model then expects the JAL one edge later and a low `fetch_stall` in that very cycle. A second overlap is a spurious data-valid during the request phase. The model expects it to have no effect until the grant.

// File: rtl/tblj_pkg.sv
package tblj_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } tj_state_e;

  localparam logic [31:0] NOP_INSN = 32'h0000_0013;
  localparam logic [6:0]  OPC_JAL  = 7'b1101111;
endpackage

// File: rtl/tblj_addr_gen.sv
module tblj_addr_gen #(
  parameter int XLEN       = 32,
  parameter int IDX_W      = 8,
  parameter int IDX_LSB    = 2,
  parameter int ALIGN_BITS = 6,
  parameter int LINK_MIN   = 32
) (
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] base,
  output logic [XLEN-1:0] entry_addr,
  output logic            link
);
  localparam int ENTRY_SHIFT = $clog2(XLEN / 8);
  localparam logic [XLEN-1:0] BASE_MASK = {{(XLEN-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  logic [IDX_W-1:0] idx;
  logic [XLEN-1:0]  idx_ext;

  always_comb begin
    idx        = instr[IDX_LSB +: IDX_W];
    idx_ext    = {{(XLEN-IDX_W){1'b0}}, idx};
    entry_addr = (base & BASE_MASK) + (idx_ext << ENTRY_SHIFT);
    link       = (idx_ext >= XLEN'(LINK_MIN));
  end
endmodule

// File: rtl/tblj_jal_build.sv
module tblj_jal_build #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] target,
  input  logic [XLEN-1:0] pc,
  input  logic            link,
  output logic [31:0]     insn
);
  import tblj_pkg::*;

  logic [XLEN-1:0] diff;
  logic [20:0]     off;
  logic [4:0]      rd;

  always_comb begin
    diff = target - pc;
    off  = diff[20:0];
    rd   = link ? 5'd1 : 5'd0;
    insn = {off[20], off[10:1], off[11], off[19:12], rd, OPC_JAL};
  end
endmodule

// File: rtl/tblj_ctrl.sv
module tblj_ctrl (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  detect,
  input  logic                  gnt,
  input  logic                  rvalid,
  output tblj_pkg::tj_state_e   state,
  output logic                  capture,
  output logic                  finish,
  output logic                  stall
);
  import tblj_pkg::*;

  tj_state_e state_q, state_d;

  always_comb begin
    capture = (state_q == ST_IDLE) && detect;
    finish  = ((state_q == ST_REQ) && gnt && rvalid) ||
              ((state_q == ST_WAIT) && rvalid);
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (detect) state_d = ST_REQ;
      ST_REQ: begin
        if (gnt && rvalid) state_d = ST_IDLE;
        else if (gnt)      state_d = ST_WAIT;
      end
      ST_WAIT: if (rvalid) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    stall = !rst && (capture || ((state_q != ST_IDLE) && !finish));
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/tblj_expander.sv
module tblj_expander #(
  parameter int XLEN       = 32,
  parameter int IDX_W      = 8,
  parameter int IDX_LSB    = 2,
  parameter int ALIGN_BITS = 6,
  parameter int LINK_MIN   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     in_instr,
  input  logic [XLEN-1:0] in_pc,
  input  logic            in_is_tj,
  input  logic            in_illegal,
  input  logic            in_compressed,
  input  logic [XLEN-1:0] tbl_base,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  input  logic            mem_gnt,
  input  logic            mem_rvalid,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [31:0]     out_instr,
  output logic            out_illegal,
  output logic            out_compressed,
  output logic            fetch_stall
);
  import tblj_pkg::*;

  tj_state_e       state;
  logic            capture, finish;
  logic [XLEN-1:0] entry_addr;
  logic            link_now;
  logic [XLEN-1:0] addr_q, pc_q;
  logic            link_q;
  logic [31:0]     jal_insn;
  logic [31:0]     out_instr_q;
  logic            out_ill_q, out_cmp_q;

  tblj_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .detect  (in_is_tj),
    .gnt     (mem_gnt),
    .rvalid  (mem_rvalid),
    .state   (state),
    .capture (capture),
    .finish  (finish),
    .stall   (fetch_stall)
  );

  tblj_addr_gen #(
    .XLEN(XLEN), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB),
    .ALIGN_BITS(ALIGN_BITS), .LINK_MIN(LINK_MIN)
  ) u_addr (
    .instr      (in_instr),
    .base       (tbl_base),
    .entry_addr (entry_addr),
    .link       (link_now)
  );

  tblj_jal_build #(.XLEN(XLEN)) u_jal (
    .target (mem_rdata),
    .pc     (pc_q),
    .link   (link_q),
    .insn   (jal_insn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      pc_q   <= '0;
      link_q <= 1'b0;
    end else if (capture) begin
      addr_q <= entry_addr;
      pc_q   <= in_pc;
      link_q <= link_now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_instr_q <= NOP_INSN;
      out_ill_q   <= 1'b0;
      out_cmp_q   <= 1'b0;
    end else if (finish) begin
      out_instr_q <= jal_insn;
      out_ill_q   <= 1'b0;
      out_cmp_q   <= 1'b1;
    end else if (capture) begin
      out_instr_q <= NOP_INSN;
      out_ill_q   <= 1'b0;
      out_cmp_q   <= 1'b0;
    end else if (state == ST_IDLE) begin
      out_instr_q <= in_instr;
      out_ill_q   <= in_illegal;
      out_cmp_q   <= in_compressed;
    end
  end

  assign mem_req        = (state == ST_REQ);
  assign mem_addr       = addr_q;
  assign out_instr      = out_instr_q;
  assign out_illegal    = out_ill_q;
  assign out_compressed = out_cmp_q;
endmodule

// File: rtl/tblj_chk.sv
module tblj_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_req,
  input logic [XLEN-1:0] mem_addr,
  input logic            mem_gnt,
  input logic            mem_rvalid,
  input logic [31:0]     out_instr,
  input logic            out_compressed,
  input logic            fetch_stall
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!mem_req && out_instr == 32'h0000_0013));

  assert_addr_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  assert_req_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_gnt) |=> !mem_req);

  assert_stall_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !(mem_gnt && mem_rvalid)) |-> fetch_stall);

  assert_same_cycle_done_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_gnt && mem_rvalid) |=> (out_instr[6:0] == 7'h6F && out_compressed));

  assert_bubble_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> (out_instr == 32'h0000_0013 && !out_compressed));
endmodule

bind tblj_expander tblj_chk #(.XLEN(XLEN)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .mem_req        (mem_req),
  .mem_addr       (mem_addr),
  .mem_gnt        (mem_gnt),
  .mem_rvalid     (mem_rvalid),
  .out_instr      (out_instr),
  .out_compressed (out_compressed),
  .fetch_stall    (fetch_stall)
);

// File: tb/tb_tblj_expander.sv
module tb_tblj_expander;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] in_instr = 32'h13, in_pc = 0, tbl_base = 0;
  logic        in_is_tj = 0, in_illegal = 0, in_compressed = 0;
  logic        mem_req, mem_gnt = 0, mem_rvalid = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic [31:0] out_instr;
  logic        out_illegal, out_compressed, fetch_stall;

  always #4 clk = ~clk;

  tblj_expander dut (
    .clk(clk), .rst(rst), .in_instr(in_instr), .in_pc(in_pc),
    .in_is_tj(in_is_tj), .in_illegal(in_illegal), .in_compressed(in_compressed),
    .tbl_base(tbl_base), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_instr(out_instr), .out_illegal(out_illegal),
    .out_compressed(out_compressed), .fetch_stall(fetch_stall)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model: 0 idle, 1 requesting, 2 waiting
  int          ms = 0;
  logic [31:0] m_addr, m_pc, m_out;
  logic        m_c, m_i, m_link;
  string       m_tag = "R1";

  function automatic logic [31:0] mk_jal(logic [31:0] tgt, logic [31:0] pc, logic lk);
    logic [31:0] o;
    o = tgt - pc;
    return (((o >> 20) & 32'h1) << 31) | (((o >> 1) & 32'h3FF) << 21) |
           (((o >> 11) & 32'h1) << 20) | (((o >> 12) & 32'hFF) << 12) |
           ((lk ? 32'd1 : 32'd0) << 7) | 32'h6F;
  endfunction

  function automatic logic [31:0] mem_of(logic [31:0] a);
    return 32'h0004_0000 + ((a & 32'hFFF) << 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ms = 0; m_out = 32'h13; m_c = 0; m_i = 0; m_tag = "R1";
    end else begin
      case (ms)
        0: if (in_is_tj) begin
             ms = 1;
             m_addr = {tbl_base[31:6], 6'd0} + 32'(in_instr[9:2]) * 4;
             m_pc = in_pc; m_link = (in_instr[9:2] >= 8'd32);
             m_out = 32'h13; m_c = 0; m_i = 0; m_tag = "R9";
           end else begin
             m_out = in_instr; m_c = in_compressed; m_i = in_illegal; m_tag = "R2";
           end
        1: if (mem_gnt && mem_rvalid) begin
             m_out = mk_jal(mem_rdata, m_pc, m_link); m_c = 1; m_i = 0; ms = 0; m_tag = "R8";
           end else if (mem_gnt) ms = 2;
        default: if (mem_rvalid) begin
             m_out = mk_jal(mem_rdata, m_pc, m_link); m_c = 1; m_i = 0; ms = 0; m_tag = "R7";
           end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // responder configuration and state
  int  cfg_g = 0, cfg_d = 0, gcnt = 0, dcnt = 0;
  bit  cfg_spur = 0, pend = 0;
  logic [31:0] paddr;

  task automatic respond();
    mem_gnt = 0; mem_rvalid = 0; mem_rdata = 32'hDEAD_BEEF;
    if (pend) begin
      if (dcnt == 0) begin mem_rvalid = 1; mem_rdata = mem_of(paddr); pend = 0; end
      else dcnt--;
    end else if (mem_req) begin
      if (gcnt == 0) begin
        mem_gnt = 1; paddr = mem_addr; gcnt = cfg_g;
        if (cfg_d == 0) begin mem_rvalid = 1; mem_rdata = mem_of(paddr); end
        else begin pend = 1; dcnt = cfg_d - 1; end
      end else begin
        gcnt--;
        if (cfg_spur) begin mem_rvalid = 1; mem_rdata = 32'h0BAD_0000; end
      end
    end
  endtask

  logic [31:0] n_instr = 32'h13, n_pc = 0, n_base = 0;
  logic        n_tj = 0, n_ill = 0, n_cmp = 0;

  task automatic step();
    bit exp_st;
    @(negedge clk);
    chk(out_instr == m_out, m_tag, out_instr, m_out);
    chk(out_compressed == m_c && out_illegal == m_i, m_tag, {out_compressed, out_illegal}, {m_c, m_i});
    if (m_tag == "R7" || m_tag == "R8")
      chk(out_instr[11:7] == (m_link ? 5'd1 : 5'd0), "R6", out_instr[11:7], m_link ? 1 : 0);
    chk(mem_req == (ms == 1), "R4", mem_req, ms == 1);
    if (ms == 1) chk(mem_addr == m_addr, "R3", mem_addr, m_addr);
    in_instr = n_instr; in_pc = n_pc; tbl_base = n_base;
    in_is_tj = n_tj; in_illegal = n_ill; in_compressed = n_cmp;
    respond();
    #1;
    if (rst) exp_st = 0;
    else if (ms == 0) exp_st = in_is_tj;
    else if (ms == 1) exp_st = !(mem_gnt && mem_rvalid);
    else exp_st = !mem_rvalid;
    chk(fetch_stall == exp_st, rst ? "R1" : "R5", fetch_stall, exp_st);
  endtask

  task automatic pass(input logic [31:0] ins, input bit ill, input bit cmp);
    n_instr = ins; n_tj = 0; n_ill = ill; n_cmp = cmp;
    step();
  endtask

  task automatic tj(input logic [7:0] idx, input logic [31:0] pc, input logic [31:0] base,
                    input int g, input int d, input bit spur, input bit scramble);
    cfg_g = g; cfg_d = d; cfg_spur = spur; gcnt = g;
    n_instr = 32'h0000_A002 | (32'(idx) << 2); n_pc = pc; n_base = base;
    n_tj = 1; n_ill = 0; n_cmp = 1;
    step();
    while (fetch_stall) begin
      if (scramble) begin  // R10: inputs altered while busy
        n_instr = n_instr ^ 32'h0000_03FC; n_pc = n_pc + 32'h40; n_base = n_base ^ 32'h100;
      end
      step();
    end
    cfg_spur = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();                  // R1 during reset
    rst = 0;
    step();                             // R1 first cycle out of reset
    pass(32'h0051_8193, 0, 0);          // R2
    pass(32'h0000_4501, 0, 1);
    pass(32'hFFFF_FFFF, 1, 0);
    pass(32'h1234_5678, 1, 1);
    tj(8'd5,   32'h0004_0100, 32'h0000_2000, 0, 1, 0, 0);  // cm.jt, R6 x0
    pass(32'h0000_0013, 0, 0);
    tj(8'd40,  32'h0004_1F00, 32'h0000_2027, 2, 3, 0, 0);  // cm.jalt, R3 unaligned base
    tj(8'd31,  32'h0004_0800, 32'h0000_3000, 3, 2, 1, 0);  // R10 spurious rvalid
    tj(8'd32,  32'h0004_0010, 32'h0000_0040, 0, 0, 0, 0);  // R8 same cycle, boundary
    tj(8'd255, 32'h0004_3000, 32'h0000_0FC0, 2, 0, 0, 0);  // R8 after delayed grant
    tj(8'd0,   32'h0004_0000, 32'h0000_0000, 1, 4, 0, 1);  // R10 scrambled inputs
    tj(8'd100, 32'h0003_0000, 32'h0000_1234, 0, 2, 0, 0);  // R7 positive offset
    pass(32'h00A0_0093, 0, 1);
    pass(32'h0000_0000, 1, 1);
    n_tj = 0;
    repeat (3) step();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule